// File: doc/BRIEF.md
# Debug Request Mailbox

This block is a small bus-slave register window through which processor software drives a debug module. Software loads a target register address and a write value, then writes an operation code. That write launches exactly one request toward the debug module over a valid/ready channel. The address and data sent are the values the registers held at the moment of launch. The reply, a 32-bit value and a pass/fail flag, is captured into read-only registers, and a response-available flag is raised.

Software works the exchange by polling a two-bit status word. Bit 0 says a new request can be launched. Bit 1 says a reply is waiting. Reading the reply status clears bit 1.

The sequencing sits in a three-state controller:
- **IDLE**: the mailbox is ready.
- **SEND**: the request is presented and held.
- **WAIT**: the request has been accepted and the reply is awaited.

Its transitions are:
- **IDLE→SEND** on a launching operation write.
- **SEND→WAIT** when the debug module accepts the request.
- **WAIT→IDLE** when the reply arrives.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, the status word (offset 0x14) reads 1, the reply data (0x0C) and reply status (0x10) read 0, and `dm_req_valid` and `dm_rsp_ready` are low.
- R2: Offset 0x00 holds a 7-bit target address. It reads back zero-extended, so writing 0xFFFFFFFF reads 0x7F. Offset 0x04 holds a 32-bit write value and reads back exactly.
- R3: While bit 0 of the status word is 1, a write to offset 0x08 whose bits [1:0] are 1 (read) or 2 (write) has three effects in the next cycle:
  - `dm_req_valid` rises.
  - `dm_req_op` carries that code.
  - Status bit 0 reads 0.
- R4: While `dm_req_valid` is high and `dm_req_ready` is low, the request address, data and operation stay unchanged. Valid stays high until a cycle in which ready is high.
- R5: Operation codes 0 (no-op) and 3 launch no request.
- R6: An operation write while status bit 0 is 0 is ignored: no second request is issued. Offset 0x08 reads back the code of the most recent launched request.
- R7: The controller moves through its states as follows:
  - After the request is accepted, `dm_rsp_ready` is high until `dm_rsp_valid` is seen.
  - In the cycle after the reply is seen, status bits 1 and 0 both read 1.
  - `dm_req_valid` and `dm_rsp_ready` are never high together.
- R8: Offset 0x0C returns the reply data. Offset 0x10 returns 0 for success and 1 for failure (`dm_rsp_err`).
- R9: A read of offset 0x10 clears status bit 1 from the next cycle, unless a reply is captured in that same cycle. A read of 0x0C does not clear it.
- R10: Changes to offsets 0x00 and 0x04 after launch do not alter the request in flight.
- R11: Writes to offsets 0x0C, 0x10, 0x14, unmapped offsets and non-word-aligned offsets have no effect. Reads of those unmapped and misaligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | WIN_W (5) | Byte offset within the window |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from `bus_addr` |
| dm_req_valid | output | 1 | Request present |
| dm_req_ready | input | 1 | Debug module takes the request |
| dm_req_addr | output | AW (7) | Target register address of the request |
| dm_req_data | output | DW (32) | Write value of the request |
| dm_req_op | output | 2 | Request code: 1 read, 2 write |
| dm_rsp_valid | input | 1 | Reply present |
| dm_rsp_ready | output | 1 | Mailbox waiting for a reply |
| dm_rsp_data | input | DW (32) | Reply data |
| dm_rsp_err | input | 1 | Reply failed when 1 |

## Verification
Read data is combinational, so the register values and status bits are due in the same cycle as the read strobe. Any state change caused by a write or a reply shows up one clock edge later. A launching write raises `dm_req_valid` in the cycle after the write. A reply sets the status flags in the cycle after `dm_rsp_valid` is seen.

The bench drives inputs on the falling edge and advances a behavioural model on each rising edge. It then compares every output, including the read data for the offset currently addressed, shortly after that same rising edge. As a result, each expected value is checked in exactly the cycle it becomes due. The stalling responder holds requests for several cycles, which exercises the hold rule and busy-time writes.

// File: rtl/dbg_mbx_pkg.sv
`timescale 1ns/1ps
package dbg_mbx_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } dm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } mbx_state_e;

    localparam int OFF_TADDR = 'h00;
    localparam int OFF_WDATA = 'h04;
    localparam int OFF_OP    = 'h08;
    localparam int OFF_RDATA = 'h0C;
    localparam int OFF_RSTAT = 'h10;
    localparam int OFF_STAT  = 'h14;

    function automatic logic op_launches(input logic [1:0] code);
        return (code == OP_READ) || (code == OP_WRITE);
    endfunction
endpackage

// File: rtl/dbg_mbx_fsm.sv
`timescale 1ns/1ps
module dbg_mbx_fsm
    import dbg_mbx_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_wr,
    input  logic [1:0]    op_code,
    input  logic [AW-1:0] taddr,
    input  logic [DW-1:0] tdata,
    input  logic          req_ready,
    input  logic          rsp_valid,
    output logic          req_valid,
    output logic          rsp_ready,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_data,
    output logic [1:0]    req_op,
    output logic          idle,
    output logic          launch,
    output logic          rsp_cap
);
    mbx_state_e state, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (op_wr && op_launches(op_code)) state_nxt = ST_SEND;
            ST_SEND: if (req_ready)                     state_nxt = ST_WAIT;
            ST_WAIT: if (rsp_valid)                     state_nxt = ST_IDLE;
            default:                                    state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle      = (state == ST_IDLE);
        req_valid = (state == ST_SEND);
        rsp_ready = (state == ST_WAIT);
        launch    = idle && op_wr && op_launches(op_code);
        rsp_cap   = rsp_ready && rsp_valid;
    end

    // request payload frozen at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr <= '0;
            req_data <= '0;
            req_op   <= OP_NONE;
        end else if (launch) begin
            req_addr <= taddr;
            req_data <= tdata;
            req_op   <= op_code;
        end
    end
endmodule

// File: rtl/dbg_mbx_regs.sv
`timescale 1ns/1ps
module dbg_mbx_regs #(
    parameter int AW = 7,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_taddr,
    input  logic          wr_tdata,
    input  logic [DW-1:0] wdata,
    input  logic          launch,
    input  logic [1:0]    launch_op,
    input  logic          rsp_cap,
    input  logic [DW-1:0] rsp_data_in,
    input  logic          rsp_err_in,
    input  logic          rstat_rd,
    output logic [AW-1:0] taddr,
    output logic [DW-1:0] tdata,
    output logic [1:0]    last_op,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_err,
    output logic          rsp_avail
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taddr <= '0;
            tdata <= '0;
        end else begin
            if (wr_taddr) taddr <= wdata[AW-1:0];
            if (wr_tdata) tdata <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      last_op <= 2'd0;
        else if (launch) last_op <= launch_op;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
            rsp_avail <= 1'b0;
        end else if (rsp_cap) begin
            rsp_data  <= rsp_data_in;
            rsp_err   <= rsp_err_in;
            rsp_avail <= 1'b1;
        end else if (rstat_rd) begin
            rsp_avail <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_mbx_rdmux.sv
`timescale 1ns/1ps
module dbg_mbx_rdmux
    import dbg_mbx_pkg::*;
#(
    parameter int AW    = 7,
    parameter int DW    = 32,
    parameter int WIN_W = 5
) (
    input  logic [WIN_W-1:0] off,
    input  logic [AW-1:0]    taddr,
    input  logic [DW-1:0]    tdata,
    input  logic [1:0]       last_op,
    input  logic [DW-1:0]    rsp_data,
    input  logic             rsp_err,
    input  logic             rsp_avail,
    input  logic             idle,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        if (off == WIN_W'(OFF_TADDR))      rdata = {{(DW-AW){1'b0}}, taddr};
        else if (off == WIN_W'(OFF_WDATA)) rdata = tdata;
        else if (off == WIN_W'(OFF_OP))    rdata = {{(DW-2){1'b0}}, last_op};
        else if (off == WIN_W'(OFF_RDATA)) rdata = rsp_data;
        else if (off == WIN_W'(OFF_RSTAT)) rdata = {{(DW-1){1'b0}}, rsp_err};
        else if (off == WIN_W'(OFF_STAT))  rdata = {{(DW-2){1'b0}}, rsp_avail, idle};
    end
endmodule

// File: rtl/dbg_mailbox.sv
`timescale 1ns/1ps
module dbg_mailbox
    import dbg_mbx_pkg::*;
#(
    parameter int AW    = 7,
    parameter int DW    = 32,
    parameter int WIN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_en,
    input  logic             bus_rd_en,
    input  logic [WIN_W-1:0] bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             dm_req_valid,
    input  logic             dm_req_ready,
    output logic [AW-1:0]    dm_req_addr,
    output logic [DW-1:0]    dm_req_data,
    output logic [1:0]       dm_req_op,
    input  logic             dm_rsp_valid,
    output logic             dm_rsp_ready,
    input  logic [DW-1:0]    dm_rsp_data,
    input  logic             dm_rsp_err
);
    logic          wr_taddr, wr_tdata, op_wr, rstat_rd;
    logic [AW-1:0] taddr;
    logic [DW-1:0] tdata, rsp_data;
    logic [1:0]    last_op;
    logic          rsp_err, rsp_avail, mbx_idle, launch, rsp_cap;

    assign wr_taddr = bus_wr_en && (bus_addr == WIN_W'(OFF_TADDR));
    assign wr_tdata = bus_wr_en && (bus_addr == WIN_W'(OFF_WDATA));
    assign op_wr    = bus_wr_en && (bus_addr == WIN_W'(OFF_OP));
    assign rstat_rd = bus_rd_en && (bus_addr == WIN_W'(OFF_RSTAT));

    dbg_mbx_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .op_wr(op_wr), .op_code(bus_wdata[1:0]),
        .taddr(taddr), .tdata(tdata),
        .req_ready(dm_req_ready), .rsp_valid(dm_rsp_valid),
        .req_valid(dm_req_valid), .rsp_ready(dm_rsp_ready),
        .req_addr(dm_req_addr), .req_data(dm_req_data), .req_op(dm_req_op),
        .idle(mbx_idle), .launch(launch), .rsp_cap(rsp_cap)
    );

    dbg_mbx_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_taddr(wr_taddr), .wr_tdata(wr_tdata), .wdata(bus_wdata),
        .launch(launch), .launch_op(bus_wdata[1:0]),
        .rsp_cap(rsp_cap), .rsp_data_in(dm_rsp_data), .rsp_err_in(dm_rsp_err),
        .rstat_rd(rstat_rd),
        .taddr(taddr), .tdata(tdata), .last_op(last_op),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_avail(rsp_avail)
    );

    dbg_mbx_rdmux #(.AW(AW), .DW(DW), .WIN_W(WIN_W)) u_rdmux (
        .off(bus_addr), .taddr(taddr), .tdata(tdata), .last_op(last_op),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_avail(rsp_avail),
        .idle(mbx_idle), .rdata(bus_rdata)
    );
endmodule

// File: rtl/dbg_mailbox_chk.sv
`timescale 1ns/1ps
module dbg_mailbox_chk
    import dbg_mbx_pkg::*;
#(
    parameter int AW    = 7,
    parameter int DW    = 32,
    parameter int WIN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd_en,
    input logic [WIN_W-1:0] bus_addr,
    input logic             dm_req_valid,
    input logic             dm_req_ready,
    input logic [AW-1:0]    dm_req_addr,
    input logic [DW-1:0]    dm_req_data,
    input logic [1:0]       dm_req_op,
    input logic             dm_rsp_valid,
    input logic             dm_rsp_ready,
    input logic             rsp_avail,
    input logic             mbx_idle
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dm_req_valid && !dm_req_ready |=> dm_req_valid && $stable(dm_req_addr)
            && $stable(dm_req_data) && $stable(dm_req_op)) else $error("req not held"); // R4

    AST_REQ_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dm_req_valid |-> (dm_req_op == OP_READ || dm_req_op == OP_WRITE)) else $error("bad op"); // R5

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dm_req_valid && dm_req_ready |=> !dm_req_valid) else $error("second request"); // R6

    AST_CHAN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dm_req_valid && dm_rsp_ready)) else $error("channels overlap"); // R7

    AST_RSP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rsp_ready && dm_rsp_valid |=> rsp_avail && mbx_idle) else $error("reply flags"); // R7

    AST_AVAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en && bus_addr == WIN_W'(OFF_RSTAT) && !(dm_rsp_ready && dm_rsp_valid)
            |=> !rsp_avail) else $error("avail not cleared"); // R9
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.AW(AW), .DW(DW), .WIN_W(WIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .dm_req_valid(dm_req_valid), .dm_req_ready(dm_req_ready),
    .dm_req_addr(dm_req_addr), .dm_req_data(dm_req_data), .dm_req_op(dm_req_op),
    .dm_rsp_valid(dm_rsp_valid), .dm_rsp_ready(dm_rsp_ready),
    .rsp_avail(rsp_avail), .mbx_idle(mbx_idle)
);

// File: tb/test_dbg_mailbox.sv
`timescale 1ns/1ps
module test_dbg_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        dm_req_valid, dm_req_ready = 1'b0;
    logic [6:0]  dm_req_addr;
    logic [31:0] dm_req_data;
    logic [1:0]  dm_req_op;
    logic        dm_rsp_valid = 1'b0, dm_rsp_ready;
    logic [31:0] dm_rsp_data = '0;
    logic        dm_rsp_err = 1'b0;

    always #2.5 clk = ~clk;

    dbg_mailbox i_dbg_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dm_req_valid(dm_req_valid), .dm_req_ready(dm_req_ready),
        .dm_req_addr(dm_req_addr), .dm_req_data(dm_req_data), .dm_req_op(dm_req_op),
        .dm_rsp_valid(dm_rsp_valid), .dm_rsp_ready(dm_rsp_ready),
        .dm_rsp_data(dm_rsp_data), .dm_rsp_err(dm_rsp_err)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // debug-module responder with programmable stalls
    int acc_dly = 0, rsp_dly = 0, wcnt = 0, hs_count = 0;
    bit rsp_e = 1'b0;
    always @(negedge clk) begin
        dm_req_ready = 1'b0;
        dm_rsp_valid = 1'b0;
        if (dm_req_valid) begin
            if (wcnt >= acc_dly) begin dm_req_ready = 1'b1; wcnt = 0; hs_count++; end
            else wcnt++;
        end else if (dm_rsp_ready) begin
            if (wcnt >= rsp_dly) begin
                dm_rsp_valid = 1'b1;
                dm_rsp_data  = 32'hC0DE_0000 | hs_count;
                dm_rsp_err   = rsp_e;
                wcnt = 0;
            end else wcnt++;
        end
    end

    // behavioural reference model
    int          m_phase;            // 0 ready, 1 presenting, 2 awaiting reply
    logic [31:0] m_addr, m_data, m_rdata;
    logic [1:0]  m_lastop, q_op;
    logic [31:0] q_addr, q_data;
    logic        m_rerr, m_avail;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_addr = 0; m_data = 0; m_rdata = 0; m_lastop = 0;
            m_rerr = 0; m_avail = 0; q_addr = 0; q_data = 0; q_op = 0;
        end else begin
            automatic int  old = m_phase;
            automatic bit  got = 1'b0;
            if (old == 1 && dm_req_ready) m_phase = 2;
            if (old == 2 && dm_rsp_valid) begin
                m_phase = 0; m_rdata = dm_rsp_data; m_rerr = dm_rsp_err;
                m_avail = 1; got = 1'b1;
            end
            if (bus_rd_en && bus_addr == 5'h10 && !got) m_avail = 0;
            if (bus_wr_en) begin
                if (bus_addr == 5'h00) m_addr = bus_wdata & 32'h7F;
                if (bus_addr == 5'h04) m_data = bus_wdata;
                if (bus_addr == 5'h08 && old == 0 &&
                    (bus_wdata[1:0] == 2'd1 || bus_wdata[1:0] == 2'd2)) begin
                    m_phase = 1; q_addr = m_addr; q_data = m_data;
                    q_op = bus_wdata[1:0]; m_lastop = bus_wdata[1:0];
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] off);
        case (off)
            5'h00: return m_addr;
            5'h04: return m_data;
            5'h08: return {30'd0, m_lastop};
            5'h0C: return m_rdata;
            5'h10: return {31'd0, m_rerr};
            5'h14: return {30'd0, m_avail, m_phase == 0};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string off_tag(input logic [4:0] off);
        case (off)
            5'h00, 5'h04: return "R2";
            5'h08:        return "R6";
            5'h0C, 5'h10: return "R8";
            5'h14:        return "R7";
            default:      return "R11";
        endcase
    endfunction

    // per-cycle comparison after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R3", {31'd0, dm_req_valid}, {31'd0, m_phase == 1});
            if (m_phase == 1) begin
                chk("R4", {25'd0, dm_req_addr}, q_addr);
                chk("R4", dm_req_data, q_data);
                chk("R4", {30'd0, dm_req_op}, {30'd0, q_op});
            end
            chk("R7", {31'd0, dm_rsp_ready}, {31'd0, m_phase == 2});
            chk(off_tag(bus_addr), bus_rdata, m_read(bus_addr));
        end
    end

    task automatic bwrite(input logic [4:0] off, input logic [31:0] v);
        bus_addr = off; bus_wdata = v; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bread(input logic [4:0] off, input string req, input logic [31:0] exp);
        bus_addr = off; bus_rd_en = 1'b1;
        #0.5;
        chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hs0;
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", {31'd0, dm_req_valid}, 32'd0);
        chk("R1", {31'd0, dm_rsp_ready}, 32'd0);
        bread(5'h14, "R1", 32'd1);
        bread(5'h0C, "R1", 32'd0);
        bread(5'h10, "R1", 32'd0);
        // R2 readback
        bwrite(5'h00, 32'hFFFF_FFFF);
        bread(5'h00, "R2", 32'h7F);
        bwrite(5'h04, 32'hDEAD_BEEF);
        bread(5'h04, "R2", 32'hDEAD_BEEF);
        bwrite(5'h00, 32'h16);
        // R3 read request, quick accept
        acc_dly = 0; rsp_dly = 2;
        bwrite(5'h08, 32'h1);
        chk("R3", {31'd0, dm_req_valid}, 32'd1);
        chk("R3", {30'd0, dm_req_op}, 32'd1);
        chk("R3", {25'd0, dm_req_addr}, 32'h16);
        bread(5'h14, "R3", 32'd0);
        idle_cycles(8);
        rv = 32'hC0DE_0000 | hs_count;
        bread(5'h14, "R7", 32'd3);
        bread(5'h0C, "R8", rv);
        bread(5'h14, "R9", 32'd3);
        bread(5'h10, "R8", 32'd0);
        bread(5'h14, "R9", 32'd1);
        // R6 / R10 busy writes during a stalled request
        acc_dly = 4; rsp_dly = 1;
        hs0 = hs_count;
        bwrite(5'h08, 32'h2);
        bwrite(5'h00, 32'h55);
        bwrite(5'h04, 32'h1234);
        bwrite(5'h08, 32'h1);
        chk("R10", {25'd0, dm_req_addr}, 32'h16);
        chk("R10", dm_req_data, 32'hDEAD_BEEF);
        chk("R10", {30'd0, dm_req_op}, 32'd2);
        idle_cycles(15);
        chk("R6", hs_count, hs0 + 1);
        bread(5'h08, "R6", 32'd2);
        bread(5'h10, "R8", 32'd0);
        // R5 no-op and reserved codes
        hs0 = hs_count;
        bwrite(5'h08, 32'h0);
        chk("R5", {31'd0, dm_req_valid}, 32'd0);
        bwrite(5'h08, 32'h3);
        chk("R5", {31'd0, dm_req_valid}, 32'd0);
        idle_cycles(3);
        chk("R5", hs_count, hs0);
        bread(5'h14, "R5", 32'd1);
        // failing reply
        rsp_e = 1'b1; acc_dly = 1; rsp_dly = 0;
        bwrite(5'h08, 32'h1);
        idle_cycles(8);
        rv = 32'hC0DE_0000 | hs_count;
        bread(5'h10, "R8", 32'd1);
        // R11 ignored writes and zero reads
        bwrite(5'h0C, 32'hFFFF_FFFF);
        bwrite(5'h10, 32'h0);
        bwrite(5'h14, 32'hFFFF_FFFF);
        bwrite(5'h01, 32'h7);
        bwrite(5'h18, 32'h9);
        bread(5'h0C, "R11", rv);
        bread(5'h10, "R11", 32'd1);
        bread(5'h14, "R11", 32'd1);
        bread(5'h00, "R11", 32'h55);
        bread(5'h18, "R11", 32'd0);
        bread(5'h1C, "R11", 32'd0);
        bread(5'h02, "R11", 32'd0);
        idle_cycles(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule